// File: doc/BRIEF.md
# PCI Initiator Burst-Start Sequencer

This block opens a PCI initiator read burst on behalf of a local agent. When the local side raises its request, the sequencer asserts the active-low bus request. It waits until the arbiter's grant is present and the bus is idle, which means both frame and initiator-ready are deasserted. It then turns its output drivers on for one cycle. In that cycle it pulses an address acknowledge so the local side can present the address and command.

On the next cycle the address phase runs. Frame is driven low, along with the 64-bit request line when a wide transfer was asked for. The byte enables are taken from the local side in the address-phase cycle and held on the command/byte-enable lines from then on. A small one-hot status vector reports which step is active: requesting, granted, or address phase. The address-phase bit is withheld when the grant was pulled away fewer than three clocks after it first appeared.

The sequencer stops in the first data phase. It holds frame and the latched byte enables there until the local side drops its request, and then returns to idle. If the grant disappears during the acknowledge cycle, the sequencer goes back to requesting and tries again.

Top module: `pciMasterStartSeq`

## Requirements
- R1: While rstN is low at a clock edge, the block returns to idle. After that edge busReqN, busFrameN and busReq64N are 1, busDrvEn and addrAck are 0, busAd and busCbe are 0, and txStatus is 3'b000.
- R2: One clock after locReq is sampled high in idle, busReqN is 0 and txStatus is 3'b001 (bit 0 means requesting).
- R3: While requesting, the block stays requesting (txStatus 3'b001, busDrvEn 0) as long as busGntN is 1, or busFrameInN is 0, or busIrdyInN is 0, for any number of cycles.
- R4: One clock after a cycle in which busGntN is 0 and busFrameInN and busIrdyInN are both 1 while requesting, addrAck is 1 for exactly one cycle, busDrvEn is 1 and txStatus is 3'b010 (bit 1 means granted).
- R5: In the cycle after the acknowledge cycle (the address phase), busFrameN is 0, busAd carries the locAddr value sampled during the acknowledge cycle, and busCbe carries the locCmd value sampled then.
- R6: busReq64N is 0 in the address phase exactly when locReq64 was 1 in the cycle locReq was accepted. Otherwise it stays 1.
- R7: busReqN stays 0 from the requesting step through the address phase and is 1 from the first data-phase cycle on.
- R8: locByteEn is sampled in the address-phase cycle and driven on busCbe throughout the data phase. Later changes on locByteEn do not affect busCbe.
- R9: In the address phase, txStatus is 3'b100 when busGntN is 0. It is 3'b000 when busGntN is 1, because the grant then lasted fewer than three clocks.
- R10: If busGntN is 1 during the acknowledge cycle, the next cycle is requesting again: txStatus 3'b001, busReqN 0, busDrvEn 0, busFrameN 1.
- R11: busDrvEn is 1 in the cycle before busFrameN first falls.
- R12: The block holds the data phase (busFrameN 0, busDrvEn 1) while locReq stays 1. One clock after locReq is sampled 0 there, it is idle with busFrameN 1 and busDrvEn 0.
- R13: txStatus never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| locReq | input | 1 | Local request to start a read burst |
| locReq64 | input | 1 | Local request for a 64-bit transfer |
| locAddr | input | 32 | Address, valid in the acknowledge cycle |
| locCmd | input | 4 | Bus command, valid in the acknowledge cycle |
| locByteEn | input | 4 | Byte enables, valid in the address-phase cycle |
| addrAck | output | 1 | One-cycle pulse asking for address and command |
| txStatus | output | 3 | One-hot progress: bit0 requesting, bit1 granted, bit2 address phase |
| busGntN | input | 1 | Arbiter grant, active low |
| busFrameInN | input | 1 | Observed bus frame, active low |
| busIrdyInN | input | 1 | Observed initiator ready, active low |
| busReqN | output | 1 | Bus request to arbiter, active low |
| busFrameN | output | 1 | Driven frame, active low |
| busReq64N | output | 1 | Driven 64-bit request, active low |
| busDrvEn | output | 1 | Output driver enable |
| busAd | output | 32 | Driven address/data lines |
| busCbe | output | 4 | Driven command/byte-enable lines |

## Verification
Grant withdrawal can coincide with two different steps. When it falls in the acknowledge cycle, it competes with the move into the address phase. When it falls in the address-phase cycle, it collides with byte-enable capture and with status reporting. The bench raises busGntN in each of these cycles, in both directed and random transactions. It then checks that the first case falls back to requesting without driving frame. In the second case it checks that frame and the captured byte enables still go out while the status bit stays clear.

// File: rtl/pciSeqPkg.sv
package pciSeqPkg;

  typedef enum logic [2:0] {
    sIdle = 3'd0,
    sReq  = 3'd1,
    sTurn = 3'd2,
    sAddr = 3'd3,
    sData = 3'd4
  } seqState_t;

  typedef struct packed {
    logic capIs64;
    logic capAddr;
    logic capBe;
    logic selAddr;
    logic selBe;
  } ctlStrobes_t;

endpackage

// File: rtl/pciSeqCtl.sv
module pciSeqCtl
  import pciSeqPkg::*;
#(
  parameter int MinGrantClocks = 3,
  parameter int StatusWidth    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   locReq,
  input  logic                   busGntN,
  input  logic                   busFrameInN,
  input  logic                   busIrdyInN,
  input  logic                   is64Held,
  output ctlStrobes_t            ctl,
  output logic                   addrAck,
  output logic [StatusWidth-1:0] txStatus,
  output logic                   busReqN,
  output logic                   busFrameN,
  output logic                   busReq64N,
  output logic                   busDrvEn
);

  localparam int RunW = $clog2(MinGrantClocks + 1);
  localparam logic [RunW-1:0] RunMax  = RunW'(MinGrantClocks);
  localparam logic [RunW-1:0] RunNeed = RunW'(MinGrantClocks - 1);

  seqState_t state, stateNext;
  logic [RunW-1:0] gntRun;
  logic busIdle, granted, grantHeld;

  assign busIdle   = busFrameInN && busIrdyInN;
  assign granted   = !busGntN;
  assign grantHeld = granted && (gntRun >= RunNeed);

  always_comb begin
    stateNext = state;
    unique case (state)
      sIdle:   if (locReq) stateNext = sReq;
      sReq:    if (granted && busIdle) stateNext = sTurn;
      sTurn:   stateNext = granted ? sAddr : sReq;
      sAddr:   stateNext = sData;
      sData:   if (!locReq) stateNext = sIdle;
      default: stateNext = sIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= sIdle;
      gntRun <= '0;
    end else begin
      state <= stateNext;
      if (!granted || state == sIdle || state == sData) gntRun <= '0;
      else if (gntRun != RunMax) gntRun <= gntRun + 1'b1;
    end
  end

  always_comb begin
    ctl.capIs64 = (state == sIdle) && locReq;
    ctl.capAddr = (state == sTurn);
    ctl.capBe   = (state == sAddr);
    ctl.selAddr = (state == sAddr);
    ctl.selBe   = (state == sData);
  end

  always_comb begin
    txStatus    = '0;
    txStatus[0] = (state == sReq);
    txStatus[1] = (state == sTurn);
    txStatus[2] = (state == sAddr) && grantHeld;
  end

  assign addrAck   = (state == sTurn);
  assign busReqN   = !(state == sReq || state == sTurn || state == sAddr);
  assign busFrameN = !(state == sAddr || state == sData);
  assign busReq64N = !((state == sAddr) && is64Held);
  assign busDrvEn  = (state == sTurn || state == sAddr || state == sData);

endmodule

// File: rtl/pciSeqDp.sv
module pciSeqDp
  import pciSeqPkg::*;
#(
  parameter int AddrWidth = 32,
  parameter int CbeWidth  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          ctl,
  input  logic                 locReq64,
  input  logic [AddrWidth-1:0] locAddr,
  input  logic [CbeWidth-1:0]  locCmd,
  input  logic [CbeWidth-1:0]  locByteEn,
  output logic                 is64Held,
  output logic [AddrWidth-1:0] busAd,
  output logic [CbeWidth-1:0]  busCbe
);

  logic [AddrWidth-1:0] addrReg;
  logic [CbeWidth-1:0]  cmdReg;
  logic [CbeWidth-1:0]  beReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      is64Held <= 1'b0;
      addrReg  <= '0;
      cmdReg   <= '0;
      beReg    <= '0;
    end else begin
      if (ctl.capIs64) is64Held <= locReq64;
      if (ctl.capAddr) begin
        addrReg <= locAddr;
        cmdReg  <= locCmd;
      end
      if (ctl.capBe) beReg <= locByteEn;
    end
  end

  always_comb begin
    busAd  = ctl.selAddr ? addrReg : '0;
    busCbe = ctl.selAddr ? cmdReg : (ctl.selBe ? beReg : '0);
  end

endmodule

// File: rtl/pciMasterStartSeq.sv
module pciMasterStartSeq
  import pciSeqPkg::*;
#(
  parameter int AddrWidth      = 32,
  parameter int CbeWidth       = 4,
  parameter int MinGrantClocks = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 locReq,
  input  logic                 locReq64,
  input  logic [AddrWidth-1:0] locAddr,
  input  logic [CbeWidth-1:0]  locCmd,
  input  logic [CbeWidth-1:0]  locByteEn,
  output logic                 addrAck,
  output logic [2:0]           txStatus,
  input  logic                 busGntN,
  input  logic                 busFrameInN,
  input  logic                 busIrdyInN,
  output logic                 busReqN,
  output logic                 busFrameN,
  output logic                 busReq64N,
  output logic                 busDrvEn,
  output logic [AddrWidth-1:0] busAd,
  output logic [CbeWidth-1:0]  busCbe
);

  ctlStrobes_t ctl;
  logic is64Held;

  pciSeqCtl #(
    .MinGrantClocks(MinGrantClocks),
    .StatusWidth(3)
  ) i_ctl (
    .clk(clk),
    .rstN(rstN),
    .locReq(locReq),
    .busGntN(busGntN),
    .busFrameInN(busFrameInN),
    .busIrdyInN(busIrdyInN),
    .is64Held(is64Held),
    .ctl(ctl),
    .addrAck(addrAck),
    .txStatus(txStatus),
    .busReqN(busReqN),
    .busFrameN(busFrameN),
    .busReq64N(busReq64N),
    .busDrvEn(busDrvEn)
  );

  pciSeqDp #(
    .AddrWidth(AddrWidth),
    .CbeWidth(CbeWidth)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .locReq64(locReq64),
    .locAddr(locAddr),
    .locCmd(locCmd),
    .locByteEn(locByteEn),
    .is64Held(is64Held),
    .busAd(busAd),
    .busCbe(busCbe)
  );

endmodule

// File: rtl/pciSeqChk.sv
module pciSeqChk #(
  parameter int CbeWidth = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                locReq,
  input logic                addrAck,
  input logic [2:0]          txStatus,
  input logic                busReqN,
  input logic                busFrameN,
  input logic                busReq64N,
  input logic                busDrvEn,
  input logic [CbeWidth-1:0] busCbe
);

  // R13
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txStatus));

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> !addrAck);

  // R11
  drv_before_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busFrameN) |-> $past(busDrvEn));

  // R7
  req_in_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busFrameN) |-> !busReqN);

  // R2
  req_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && busReqN && !busDrvEn) |=> !busReqN);

  // R6
  req64_with_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq64N |-> !busFrameN);

  // R8
  be_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busFrameN && busReqN && $past(!busFrameN) && $past(busReqN)) |-> $stable(busCbe));

endmodule

bind pciMasterStartSeq pciSeqChk #(.CbeWidth(CbeWidth)) i_pciSeqChk (
  .clk(clk),
  .rstN(rstN),
  .locReq(locReq),
  .addrAck(addrAck),
  .txStatus(txStatus),
  .busReqN(busReqN),
  .busFrameN(busFrameN),
  .busReq64N(busReq64N),
  .busDrvEn(busDrvEn),
  .busCbe(busCbe)
);

// File: tb/test_pciMasterStartSeq.sv
`timescale 1ns/1ps
module test_pciMasterStartSeq;

  logic clk = 1'b0;
  logic rstN;
  logic locReq, locReq64;
  logic [31:0] locAddr;
  logic [3:0] locCmd, locByteEn;
  logic addrAck;
  logic [2:0] txStatus;
  logic busGntN, busFrameInN, busIrdyInN;
  logic busReqN, busFrameN, busReq64N, busDrvEn;
  logic [31:0] busAd;
  logic [3:0] busCbe;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pciMasterStartSeq i_pciMasterStartSeq (
    .clk(clk), .rstN(rstN), .locReq(locReq), .locReq64(locReq64),
    .locAddr(locAddr), .locCmd(locCmd), .locByteEn(locByteEn),
    .addrAck(addrAck), .txStatus(txStatus), .busGntN(busGntN),
    .busFrameInN(busFrameInN), .busIrdyInN(busIrdyInN), .busReqN(busReqN),
    .busFrameN(busFrameN), .busReq64N(busReq64N), .busDrvEn(busDrvEn),
    .busAd(busAd), .busCbe(busCbe)
  );

  function automatic logic [2:0] expAddrStatus(input logic gntLow);
    return gntLow ? 3'b100 : 3'b000;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  // One transaction; dropAt: 0 none, 1 in ack cycle, 2 in address phase
  task automatic runTxn(input logic is64, input logic [31:0] addr, input logic [3:0] cmd,
                        input logic [3:0] be, input int waits, input int dropAt, input int holdData);
    locReq = 1'b1; locReq64 = is64; busGntN = 1'b1;
    tick();
    check("R2", "busReqN", busReqN, 0);
    check("R2", "txStatus", txStatus, 3'b001);
    locReq64 = ~is64;
    for (int w = 0; w < waits; w++) begin
      case ($urandom_range(2, 0))
        0: begin busGntN = 1'b1; busFrameInN = 1'b1; busIrdyInN = 1'b1; end
        1: begin busGntN = 1'b0; busFrameInN = 1'b0; busIrdyInN = 1'b1; end
        default: begin busGntN = 1'b0; busFrameInN = 1'b1; busIrdyInN = 1'b0; end
      endcase
      tick();
      check("R3", "txStatus wait", txStatus, 3'b001);
      check("R3", "busDrvEn wait", busDrvEn, 0);
    end
    busGntN = 1'b0; busFrameInN = 1'b1; busIrdyInN = 1'b1;
    tick();
    check("R4", "addrAck", addrAck, 1);
    check("R4", "busDrvEn", busDrvEn, 1);
    check("R4", "txStatus", txStatus, 3'b010);
    check("R11", "frame high in ack", busFrameN, 1);
    if (dropAt == 1) begin
      busGntN = 1'b1;
      locAddr = ~addr;
      tick();
      check("R10", "txStatus", txStatus, 3'b001);
      check("R10", "busReqN", busReqN, 0);
      check("R10", "busDrvEn", busDrvEn, 0);
      check("R10", "busFrameN", busFrameN, 1);
      busGntN = 1'b0;
      tick();
      check("R4", "addrAck retry", addrAck, 1);
    end
    locAddr = addr; locCmd = cmd;
    tick();
    locAddr = ~addr; locCmd = ~cmd; locByteEn = be;
    if (dropAt == 2) busGntN = 1'b1;
    #0.5;
    check("R5", "busFrameN", busFrameN, 0);
    check("R5", "busAd", busAd, addr);
    check("R5", "busCbe cmd", busCbe, {28'd0, cmd});
    check("R4", "addrAck ended", addrAck, 0);
    check("R6", "busReq64N", busReq64N, !is64);
    check("R7", "busReqN addr", busReqN, 0);
    check("R9", "txStatus addr", txStatus, expAddrStatus(dropAt != 2));
    tick();
    locByteEn = ~be;
    busGntN = 1'b1;
    #0.5;
    check("R8", "busCbe be", busCbe, {28'd0, be});
    check("R7", "busReqN data", busReqN, 1);
    check("R6", "busReq64N data", busReq64N, 1);
    for (int h = 0; h < holdData; h++) begin
      locByteEn = 4'($urandom);
      tick();
      check("R8", "busCbe held", busCbe, {28'd0, be});
      check("R12", "frame held", busFrameN, 0);
      check("R12", "drv held", busDrvEn, 1);
    end
    locReq = 1'b0;
    tick();
    check("R12", "busFrameN idle", busFrameN, 1);
    check("R12", "busDrvEn idle", busDrvEn, 0);
    check("R12", "busReqN idle", busReqN, 1);
    check("R12", "txStatus idle", txStatus, 3'b000);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; locReq = 1'b0; locReq64 = 1'b0; locAddr = '0; locCmd = '0;
    locByteEn = '0; busGntN = 1'b1; busFrameInN = 1'b1; busIrdyInN = 1'b1;
    repeat (3) tick();
    check("R1", "busReqN", busReqN, 1);
    check("R1", "busFrameN", busFrameN, 1);
    check("R1", "busReq64N", busReq64N, 1);
    check("R1", "busDrvEn", busDrvEn, 0);
    check("R1", "addrAck", addrAck, 0);
    check("R1", "txStatus", txStatus, 3'b000);
    check("R1", "busAd", busAd, 0);
    check("R1", "busCbe", busCbe, 0);
    rstN = 1'b1;
    tick();
    runTxn(1'b1, 32'hDEAD_BEEF, 4'h6, 4'h0, 0, 0, 1);
    runTxn(1'b0, 32'h1234_5678, 4'hE, 4'h3, 4, 1, 0);
    runTxn(1'b1, 32'h0000_0040, 4'hC, 4'hA, 2, 2, 2);
    for (int t = 0; t < 30; t++)
      runTxn(1'($urandom), $urandom, 4'($urandom), 4'($urandom),
             $urandom_range(6, 0), $urandom_range(2, 0), $urandom_range(3, 0));
    // reset in the middle of a transaction
    locReq = 1'b1;
    tick();
    busGntN = 1'b0;
    tick();
    rstN = 1'b0; locReq = 1'b0;
    tick();
    check("R1", "busDrvEn mid reset", busDrvEn, 0);
    check("R1", "txStatus mid reset", txStatus, 3'b000);
    check("R1", "busReqN mid reset", busReqN, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule